// File: doc/BRIEF.md
# Pulse Parameter Microinstruction Sequencer

This block steps through a program of fixed-width microinstruction words and, for a group of waveform-output channels, maintains an amplitude, a frequency and a phase register per channel. Each word carries a channel mask, so one word can rewrite the same parameter on several channels in a single cycle. Each word also carries a predicate selector, which makes the word conditional on a one-bit flag. A parameter sweep is written as a run of immediate writes to these registers; stored waveforms are never reloaded. Waveform synthesis, converters, envelope storage and program loading all sit outside the block.

Besides the parameter writes, the sequencer can start a pulse, which gives the masked channels a strobe together with an envelope number and a length. It can also hold for a programmed number of ticks, handshake with an external unit, and fire an acquisition trigger whose one-bit result sets the flag. Every channel shares one time base: one clock cycle is one tick. The program memory lies outside the block. The sequencer presents a word address, and the word at that address is returned in the same cycle.

Top module: `pulse_seq`

## Requirements
- R1: The 64-bit word holds these fields, from bit 63 down: opcode [63:58], channel mask [57:42], predicate selector [41:40], envelope number [39:32], duration in ticks [31:16], immediate [15:0]. Mask bit c selects channel c.
- R2: Opcode 0x01 writes the immediate to the amplitude register of every masked channel, 0x02 writes it to the frequency register, and 0x03 writes it to the phase register. All masked channels change together, the change is visible the cycle after the word executes, and unmasked channels keep their values.
- R3: Opcode 0x04 writes immediate[15:8] to amplitude and immediate[7:0] to phase (both zero-extended) on the masked channels. For one cycle it raises the start strobe of those channels and presents the envelope number and duration of the word.
- R4: Opcode 0x08 with duration D>0 delays execution of the next word by exactly D ticks. With D=0 the next word follows in the next cycle.
- R5: Opcode 0x09 raises the sync request from the cycle after it executes. The request holds, and the program counter holds, until the acknowledge input is sampled high. The next word executes in the cycle after that.
- R6: Opcode 0x0C raises the acquisition trigger of the masked channels for exactly one cycle. At the end of that cycle the flag takes the acquisition result input, and the next word executes one cycle after the trigger.
- R7: Predicate selector encoding: 00 always executes, 01 executes when the flag is 1, 10 executes when the flag is 0, and 11 never executes.
- R8: A word whose predicate is false changes no register, strobe, trigger, request or flag. Its only effect is that the program counter advances by one in the next cycle.
- R9: Any other opcode value sets a sticky error output and halts the sequencer with the program counter frozen, whatever the predicate selector says.
- R10: After reset the program counter is 0, all parameter registers, strobes, triggers, the flag, the sync request and the error output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle is one tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_o | output | PC_W | Address of the word being fetched |
| instr_i | input | 64 | Word at address pc_o |
| sync_ack_i | input | 1 | Acknowledge from the external unit |
| acq_bit_i | input | 1 | Acquisition result bit |
| amp_o | output | NCH*16 | Amplitude registers, channel c at [16c+15:16c] |
| freq_o | output | NCH*16 | Frequency registers |
| phase_o | output | NCH*16 | Phase registers |
| start_o | output | NCH | Pulse-start strobes |
| env_o | output | 8 | Envelope number of the last pulse start |
| dur_o | output | 16 | Duration of the last pulse start |
| trig_o | output | NCH | Acquisition triggers |
| sync_req_o | output | 1 | Sync request |
| pred_flag_o | output | 1 | Predicate flag |
| err_o | output | 1 | Sticky illegal-opcode error |

## Verification
The assertions are checked on every cycle. They cover these rules: the error output never clears and freezes the program counter; a pending sync request holds both itself and the counter; an acquisition trigger lasts one cycle and is followed by the flag taking the result; a start strobe and a trigger never coincide; and a start strobe comes with a one-step advance of the counter. The bench scenarios show the rest. One scenario sweeps the masks, opcodes and predicate selectors of the parameter writes against a value model. Another shows the exact delay length, including duration zero. Others cover flag-dependent execution after acquisitions, a predicated-off acquisition that leaves the flag alone, and a halt that ignores its predicate.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int WORD_W = 64;
  localparam int PARAM_W = 16;

  typedef struct packed {
    logic [5:0]  opc;
    logic [15:0] mask;
    logic [1:0]  pred;
    logic [7:0]  env;
    logic [15:0] dur;
    logic [15:0] imm;
  } uword_t;

  localparam logic [5:0] OP_AMP   = 6'h01;
  localparam logic [5:0] OP_FREQ  = 6'h02;
  localparam logic [5:0] OP_PHASE = 6'h03;
  localparam logic [5:0] OP_AMPPH = 6'h04;
  localparam logic [5:0] OP_DELAY = 6'h08;
  localparam logic [5:0] OP_SYNC  = 6'h09;
  localparam logic [5:0] OP_ACQ   = 6'h0C;

  typedef enum logic [2:0] {S_RUN, S_WAIT, S_SYNC, S_CAPT, S_HALT} seq_state_e;
endpackage

// File: rtl/mseq_decode.sv
module mseq_decode
  import mseq_pkg::*;
(
  input  uword_t w_i,
  input  logic   flag_i,
  output logic   legal_o,
  output logic   pred_ok_o,
  output logic   is_amp_o,
  output logic   is_freq_o,
  output logic   is_phase_o,
  output logic   is_ampph_o,
  output logic   is_delay_o,
  output logic   is_sync_o,
  output logic   is_acq_o
);
  always_comb begin
    is_amp_o   = w_i.opc == OP_AMP;
    is_freq_o  = w_i.opc == OP_FREQ;
    is_phase_o = w_i.opc == OP_PHASE;
    is_ampph_o = w_i.opc == OP_AMPPH;
    is_delay_o = w_i.opc == OP_DELAY;
    is_sync_o  = w_i.opc == OP_SYNC;
    is_acq_o   = w_i.opc == OP_ACQ;
    legal_o    = is_amp_o | is_freq_o | is_phase_o | is_ampph_o |
                 is_delay_o | is_sync_o | is_acq_o;
  end

  // R7 predicate selector
  always_comb begin
    unique case (w_i.pred)
      2'b00:   pred_ok_o = 1'b1;
      2'b01:   pred_ok_o = flag_i;
      2'b10:   pred_ok_o = !flag_i;
      default: pred_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mseq_chan.sv
module mseq_chan #(
  parameter int PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_amp_i,
  input  logic          we_freq_i,
  input  logic          we_phase_i,
  input  logic [PW-1:0] amp_d_i,
  input  logic [PW-1:0] freq_d_i,
  input  logic [PW-1:0] phase_d_i,
  output logic [PW-1:0] amp_q_o,
  output logic [PW-1:0] freq_q_o,
  output logic [PW-1:0] phase_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      amp_q_o   <= '0;
      freq_q_o  <= '0;
      phase_q_o <= '0;
    end else begin
      if (we_amp_i)   amp_q_o   <= amp_d_i;
      if (we_freq_i)  freq_q_o  <= freq_d_i;
      if (we_phase_i) phase_q_o <= phase_d_i;
    end
  end
endmodule

// File: rtl/pulse_seq.sv
module pulse_seq
  import mseq_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int PC_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [PC_W-1:0]    pc_o,
  input  logic [WORD_W-1:0]  instr_i,
  input  logic               sync_ack_i,
  input  logic               acq_bit_i,
  output logic [NCH*16-1:0]  amp_o,
  output logic [NCH*16-1:0]  freq_o,
  output logic [NCH*16-1:0]  phase_o,
  output logic [NCH-1:0]     start_o,
  output logic [7:0]         env_o,
  output logic [15:0]        dur_o,
  output logic [NCH-1:0]     trig_o,
  output logic               sync_req_o,
  output logic               pred_flag_o,
  output logic               err_o
);
  localparam int HALF_W = PARAM_W / 2;

  uword_t w;
  assign w = uword_t'(instr_i);

  seq_state_e         st_q;
  logic [PC_W-1:0]    pc_q;
  logic [15:0]        cnt_q;
  logic               flag_q, err_q;
  logic [NCH-1:0]     start_q, trig_q;
  logic [7:0]         env_q;
  logic [15:0]        dur_q;

  logic legal, pred_ok, is_amp, is_freq, is_phase, is_ampph, is_delay, is_sync, is_acq;

  mseq_decode u_dec (
    .w_i(w), .flag_i(flag_q), .legal_o(legal), .pred_ok_o(pred_ok),
    .is_amp_o(is_amp), .is_freq_o(is_freq), .is_phase_o(is_phase),
    .is_ampph_o(is_ampph), .is_delay_o(is_delay), .is_sync_o(is_sync),
    .is_acq_o(is_acq)
  );

  logic           fire;
  logic [NCH-1:0] sel;
  logic [15:0]    amp_d, phase_d;
  assign fire    = (st_q == S_RUN) && legal && pred_ok;
  assign sel     = w.mask[NCH-1:0];
  assign amp_d   = is_ampph ? {{HALF_W{1'b0}}, w.imm[15:8]} : w.imm;
  assign phase_d = is_ampph ? {{HALF_W{1'b0}}, w.imm[7:0]}  : w.imm;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    mseq_chan #(.PW(PARAM_W)) u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .we_amp_i(fire && sel[c] && (is_amp || is_ampph)),
      .we_freq_i(fire && sel[c] && is_freq),
      .we_phase_i(fire && sel[c] && (is_phase || is_ampph)),
      .amp_d_i(amp_d), .freq_d_i(w.imm), .phase_d_i(phase_d),
      .amp_q_o(amp_o[c*PARAM_W +: PARAM_W]),
      .freq_q_o(freq_o[c*PARAM_W +: PARAM_W]),
      .phase_q_o(phase_o[c*PARAM_W +: PARAM_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_RUN;
      pc_q    <= '0;
      cnt_q   <= '0;
      flag_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= '0;
      trig_q  <= '0;
      env_q   <= '0;
      dur_q   <= '0;
    end else begin
      start_q <= '0;
      trig_q  <= '0;
      unique case (st_q)
        S_RUN: begin
          if (!legal) begin
            err_q <= 1'b1;  // R9: checked before the predicate
            st_q  <= S_HALT;
          end else begin
            pc_q <= pc_q + PC_W'(1);
            if (pred_ok) begin
              if (is_ampph) begin
                start_q <= sel;
                env_q   <= w.env;
                dur_q   <= w.dur;
              end
              if (is_delay && w.dur != '0) begin
                cnt_q <= w.dur - 16'd1;
                st_q  <= S_WAIT;
              end
              if (is_sync) st_q <= S_SYNC;
              if (is_acq) begin
                trig_q <= sel;
                st_q   <= S_CAPT;
              end
            end
          end
        end
        S_WAIT: begin
          if (cnt_q == '0) st_q <= S_RUN;
          else             cnt_q <= cnt_q - 16'd1;
        end
        S_SYNC: if (sync_ack_i) st_q <= S_RUN;
        S_CAPT: begin
          flag_q <= acq_bit_i;
          st_q   <= S_RUN;
        end
        default: st_q <= S_HALT;
      endcase
    end
  end

  assign pc_o        = pc_q;
  assign start_o     = start_q;
  assign env_o       = env_q;
  assign dur_o       = dur_q;
  assign trig_o      = trig_q;
  assign sync_req_o  = st_q == S_SYNC;
  assign pred_flag_o = flag_q;
  assign err_o       = err_q;
endmodule

// File: rtl/pulse_seq_chk.sv
module pulse_seq_chk #(
  parameter int NCH  = 16,
  parameter int PC_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] pc_o,
  input logic            sync_ack_i,
  input logic            acq_bit_i,
  input logic [NCH-1:0]  start_o,
  input logic [NCH-1:0]  trig_o,
  input logic            sync_req_o,
  input logic            pred_flag_o,
  input logic            err_o
);
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_halt_pc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> $stable(pc_o));
  p_sync_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_req_o && !sync_ack_i) |=> (sync_req_o && $stable(pc_o)));
  p_trig_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|trig_o) |=> (trig_o == '0));
  p_flag_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|trig_o) |=> (pred_flag_o == $past(acq_bit_i)));
  p_start_trig_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|start_o) && (|trig_o)));
  p_start_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_o) |-> (pc_o == $past(pc_o) + PC_W'(1)));
endmodule

bind pulse_seq pulse_seq_chk #(.NCH(NCH), .PC_W(PC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pc_o(pc_o), .sync_ack_i(sync_ack_i),
  .acq_bit_i(acq_bit_i), .start_o(start_o), .trig_o(trig_o),
  .sync_req_o(sync_req_o), .pred_flag_o(pred_flag_o), .err_o(err_o)
);

// File: tb/sim_pulse_seq.sv
`timescale 1ns/1ps
module sim_pulse_seq;
  localparam int NCH = 4;
  localparam int PC_W = 6;

  logic clk = 1'b0, rst_n = 1'b0, ack = 1'b0, acq = 1'b0;
  logic [PC_W-1:0] pc;
  logic [63:0] instr;
  logic [NCH*16-1:0] amp, freq, phase;
  logic [NCH-1:0] start, trig;
  logic [7:0] env;
  logic [15:0] dur;
  logic sync_req, flag, err;
  logic [63:0] imem [64];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign instr = imem[pc];

  pulse_seq #(.NCH(NCH), .PC_W(PC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pc_o(pc), .instr_i(instr),
    .sync_ack_i(ack), .acq_bit_i(acq), .amp_o(amp), .freq_o(freq),
    .phase_o(phase), .start_o(start), .env_o(env), .dur_o(dur),
    .trig_o(trig), .sync_req_o(sync_req), .pred_flag_o(flag), .err_o(err)
  );

  // R1 field layout
  function automatic logic [63:0] mk(input logic [5:0] op, input logic [15:0] m,
      input logic [1:0] p, input logic [7:0] e, input logic [15:0] d, input logic [15:0] i);
    return {op, m, p, e, d, i};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  logic [15:0] ea [NCH], ef [NCH], ep [NCH];

  task automatic chk_regs(input string tag);
    for (int c = 0; c < NCH; c++) begin
      chk({tag, " amp"}, 64'(amp[c*16 +: 16]), 64'(ea[c]));
      chk({tag, " freq"}, 64'(freq[c*16 +: 16]), 64'(ef[c]));
      chk({tag, " phase"}, 64'(phase[c*16 +: 16]), 64'(ep[c]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // ---------- sweep of parameter writes, flag = 0 throughout ----------
    for (int i = 0; i < 64; i++) imem[i] = 64'h0;
    for (int i = 0; i < 60; i++) begin
      logic [5:0] op;
      logic [1:0] p;
      op = (i % 4 == 0) ? 6'h01 : (i % 4 == 1) ? 6'h02 : (i % 4 == 2) ? 6'h03 : 6'h04;
      p = (i % 7 == 3) ? 2'b01 : (i % 11 == 5) ? 2'b11 : (i % 5 == 2) ? 2'b10 : 2'b00;
      imem[i] = mk(op, 16'((i / 4) % 16), p, 8'(i + 1), 16'(i + 100),
                   16'(i * 16'h0731) ^ 16'h5a5a);
    end
    do_reset();
    for (int c = 0; c < NCH; c++) begin ea[c] = '0; ef[c] = '0; ep[c] = '0; end
    chk("R10 pc", 64'(pc), 0);
    chk("R10 err", 64'(err), 0);
    chk("R10 flag", 64'(flag), 0);
    chk("R10 sync_req", 64'(sync_req), 0);
    chk("R10 strobes", 64'({start, trig}), 0);
    chk_regs("R10");
    for (int i = 0; i < 60; i++) begin
      logic [63:0] wd;
      logic ok;
      logic [NCH-1:0] es;
      wd = imem[i];
      ok = (wd[41:40] == 2'b00) || (wd[41:40] == 2'b10); // R7 with flag 0
      es = '0;
      if (ok) begin
        for (int c = 0; c < NCH; c++) if (wd[42 + c]) begin
          case (wd[63:58])
            6'h01: ea[c] = wd[15:0];
            6'h02: ef[c] = wd[15:0];
            6'h03: ep[c] = wd[15:0];
            default: begin ea[c] = {8'h0, wd[15:8]}; ep[c] = {8'h0, wd[7:0]}; end
          endcase
        end
        if (wd[63:58] == 6'h04) es = wd[42 +: NCH];
      end
      step();
      chk_regs(ok ? "R2" : "R8");
      chk("R3 start", 64'(start), 64'(es));
      if (es != '0) begin
        chk("R3 env", 64'(env), 64'(wd[39:32]));
        chk("R3 dur", 64'(dur), 64'(wd[31:16]));
      end
      chk(ok ? "R2 pc" : "R8 pc", 64'(pc), 64'(i + 1));
    end
    step();
    chk("R9 err", 64'(err), 1);
    repeat (3) step();
    chk("R9 pc frozen", 64'(pc), 60);
    chk_regs("R9");

    // ---------- timing, sync, acquisition and predicate scenarios ----------
    for (int i = 0; i < 64; i++) imem[i] = 64'h0;
    imem[0]  = mk(6'h0C, 16'b0101, 2'b00, 0, 0, 0);
    imem[1]  = mk(6'h01, 16'b0001, 2'b01, 0, 0, 16'h1111);
    imem[2]  = mk(6'h01, 16'b0010, 2'b10, 0, 0, 16'h2222);
    imem[3]  = mk(6'h08, 16'h0, 2'b00, 0, 16'd5, 0);
    imem[4]  = mk(6'h02, 16'b1111, 2'b00, 0, 0, 16'h0044);
    imem[5]  = mk(6'h08, 16'h0, 2'b00, 0, 16'd0, 0);
    imem[6]  = mk(6'h02, 16'b0001, 2'b00, 0, 0, 16'h0066);
    imem[7]  = mk(6'h09, 16'h0, 2'b00, 0, 0, 0);
    imem[8]  = mk(6'h0C, 16'b1000, 2'b00, 0, 0, 0);
    imem[9]  = mk(6'h03, 16'b0100, 2'b10, 0, 0, 16'h0ABC);
    imem[10] = mk(6'h0C, 16'b1111, 2'b11, 0, 0, 0);
    imem[11] = mk(6'h01, 16'b1000, 2'b01, 0, 0, 16'h7777);
    imem[12] = mk(6'h3F, 16'hFFFF, 2'b11, 0, 0, 16'h1234);
    acq = 1'b1;
    do_reset();
    chk("R10 err after reset", 64'(err), 0);
    chk("R10 pc after reset", 64'(pc), 0);
    step();
    chk("R6 trig", 64'(trig), 64'b0101);
    step();
    chk("R6 trig one tick", 64'(trig), 0);
    chk("R6 flag", 64'(flag), 1);
    chk("R6 stall pc", 64'(pc), 1);
    step();
    chk("R7 pred01 flag1 amp0", 64'(amp[15:0]), 16'h1111);
    step();
    chk("R8 pred10 flag1 amp1", 64'(amp[31:16]), 0);
    chk("R8 pc", 64'(pc), 3);
    step();
    for (int j = 0; j < 5; j++) begin
      step();
      chk("R4 delay pc", 64'(pc), 4);
      chk("R4 delay freq", 64'(freq[15:0]), 0);
    end
    step();
    chk("R4 after delay freq3", 64'(freq[63:48]), 16'h0044);
    chk("R4 after delay pc", 64'(pc), 5);
    step();
    step();
    chk("R4 zero delay freq0", 64'(freq[15:0]), 16'h0066);
    chk("R4 zero delay pc", 64'(pc), 7);
    step();
    for (int j = 0; j < 6; j++) begin
      chk("R5 sync_req", 64'(sync_req), 1);
      chk("R5 pc hold", 64'(pc), 8);
      step();
    end
    ack = 1'b1;
    step();
    chk("R5 released", 64'(sync_req), 0);
    chk("R5 pc", 64'(pc), 8);
    ack = 1'b0;
    acq = 1'b0;
    step();
    chk("R6 trig ch3", 64'(trig), 64'b1000);
    step();
    chk("R6 flag cleared", 64'(flag), 0);
    step();
    chk("R7 pred10 flag0 phase2", 64'(phase[47:32]), 16'h0ABC);
    acq = 1'b1;
    step();
    chk("R8 predicated acq trig", 64'(trig), 0);
    chk("R8 predicated acq pc", 64'(pc), 11);
    step();
    chk("R8 predicated acq flag", 64'(flag), 0);
    chk("R7 pred01 flag0 amp3", 64'(amp[63:48]), 0);
    chk("R8 pc", 64'(pc), 12);
    step();
    chk("R9 err pred11", 64'(err), 1);
    repeat (3) step();
    chk("R9 pc", 64'(pc), 12);
    chk("R9 sticky", 64'(err), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule